// File: doc/BRIEF.md
# Branch and Subroutine Flow Sequencer

This sequencer carries out the program-flow group of a processor with 16-bit opcode words. It covers six operations: the conditional branch, the unconditional branch, the subroutine call, the counted loop (decrement and branch), the subroutine return and the stack-frame link. The caller has already picked the operation and presents it as a small kind code. It also presents the opcode word, the four status flags, the program counter (already pointing past the opcode word), the stack pointer, and the address and data registers that the opcode names. A one-cycle `start` launches the operation.

When an operation needs an extension word, a stack push or a stack pop, the sequencer issues requests on a simple memory port. It waits on each acknowledge for as long as memory takes. When the operation completes it raises `done` for one cycle. In that cycle it presents the next program counter, the updated stack pointer and registers, and the instruction's cycle cost. Every displacement is sign-extended to 32 bits and added to the incoming program counter.

Top module: `flow_seq`

## Requirements
- R1: The condition field is opcode bits 11:8. Its values are: 0 always, 1 never, 2 !C&!Z, 3 C|Z, 4 !C, 5 C, 6 !Z, 7 Z, 8 !V, 9 V, 10 !N, 11 N, 12 N==V, 13 N!=V, 14 (N==V)&!Z, 15 Z|(N!=V). The conditional branch (kind 0) is taken exactly when the selected condition holds.
- R2: A nonzero low opcode byte is a signed 8-bit displacement. A taken branch yields PC+disp with cost 10. A not-taken branch leaves PC unchanged with cost 8. Neither case makes a memory access.
- R3: A zero low byte selects a 16-bit signed extension word. If the branch is taken, one word read is made at PC and the result is PC+ext with cost 10. If it is not taken, no access is made and the result is PC+2 with cost 12.
- R4: The unconditional branch (kind 1) ignores the condition field and the flags, and always branches with cost 10.
- R5: The subroutine call (kind 2) lowers SP by 4 and writes the return address as a long at the new SP. The return address is PC for a short displacement, or PC+2 after the extension word is read. It then branches, with cost 18.
- R6: The counted loop (kind 3), when its condition holds, gives PC+2 with cost 12 and leaves the data register unchanged.
- R7: When the loop condition fails, the low half of the data register is decremented. If it wraps to 0xFFFF the result is PC+2 with cost 14. The upper half is never altered.
- R8: When the loop condition fails and the low half does not wrap, the extension word at PC is read and the result is PC+ext with cost 10.
- R9: The return (kind 4) reads a long at SP, loads PC from it and adds 4 to SP, with cost 16.
- R10: The link (kind 5) reads an offset word at PC and pushes the address register as a long at SP-4. SP becomes SP-4, the address register becomes SP-4+offset and PC becomes PC+2, with cost 16.
- R11: A request keeps its address and direction until acknowledged. Each access lasts one cycle more than the memory's wait cycles. `done` is one cycle wide and arrives one cycle after `start` plus the time taken by the accesses.
- R12: Kinds 6 and 7 complete with PC unchanged and cost 4. `start` is ignored while the sequencer is busy.
- R13: After reset, `done`, `busy` and `mem_req` are low and the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch an operation (sampled when idle) |
| kind | input | 3 | 0 cond branch, 1 branch, 2 call, 3 loop, 4 return, 5 link |
| opcode | input | 16 | Opcode word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 32 | PC pointing after the opcode word |
| sp_in | input | 32 | Stack pointer |
| areg_in | input | 32 | Selected address register |
| dreg_in | input | 32 | Selected data register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write request |
| mem_long | output | 1 | Long (1) or word (0) access |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge |
| mem_rdata | input | 32 | Read data (word reads use bits 15:0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 32 | Next PC |
| sp_out | output | 32 | Updated stack pointer |
| areg_out | output | 32 | Updated address register |
| dreg_out | output | 32 | Updated data register |
| cycles | output | 5 | Cycle cost of the operation |

## Verification
When an operation needs no memory, `done` and its results are due at the first clock edge after `start` is sampled. Each memory access adds the memory's wait cycles plus one. The bench counts cycles from the `start` edge to `done` and compares the count with the total expected for that operation and memory latency. It reads every result in that same `done` cycle, half a period away from the edge. Memory latency is set per test, and the extension word, pop value and write capture are driven on the falling edge, so that the acknowledge timing is fixed independently of the design.

// File: rtl/flow_seq.sv
module flow_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  kind,
  input  logic [15:0] opcode,
  input  logic        flag_n,
  input  logic        flag_z,
  input  logic        flag_v,
  input  logic        flag_c,
  input  logic [31:0] pc_in,
  input  logic [31:0] sp_in,
  input  logic [31:0] areg_in,
  input  logic [31:0] dreg_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_long,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] pc_out,
  output logic [31:0] sp_out,
  output logic [31:0] areg_out,
  output logic [31:0] dreg_out,
  output logic [4:0]  cycles
);

  typedef enum logic [2:0] {S_IDLE, S_EXT, S_PUSH, S_POP, S_DONE} st_t;
  localparam logic [2:0] K_BCC = 3'd0, K_BRA = 3'd1, K_BSR = 3'd2,
                         K_LOOP = 3'd3, K_RET = 3'd4, K_LINK = 3'd5;

  st_t         st;
  logic [2:0]  r_kind;
  logic [31:0] r_pc, r_sp, r_a, r_d, r_wd;
  logic [4:0]  r_cyc;

  function automatic logic cond_hold(input logic [3:0] cc,
                                     input logic n, z, v, c);
    case (cc)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return !c && !z;
      4'd3:  return c || z;
      4'd4:  return !c;
      4'd5:  return c;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return (n == v) && !z;
      default: return z || (n != v);
    endcase
  endfunction

  logic        cc_ok, taken, short_d;
  logic [31:0] sx8, sx16;
  logic [15:0] dec;
  logic        unused_hi;

  assign cc_ok     = cond_hold(opcode[11:8], flag_n, flag_z, flag_v, flag_c);
  assign taken     = (kind == K_BRA) || cc_ok;
  assign short_d   = |opcode[7:0];
  assign sx8       = {{24{opcode[7]}}, opcode[7:0]};
  assign sx16      = {{16{mem_rdata[15]}}, mem_rdata[15:0]};
  assign dec       = dreg_in[15:0] - 16'd1;
  assign unused_hi = &{1'b0, opcode[15:12], mem_rdata[31:16]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; r_kind <= '0; r_pc <= '0; r_sp <= '0;
      r_a <= '0; r_d <= '0; r_wd <= '0; r_cyc <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          r_kind <= kind; r_pc <= pc_in; r_sp <= sp_in;
          r_a <= areg_in; r_d <= dreg_in;
          case (kind)
            K_BCC, K_BRA:
              if (short_d) begin
                r_pc  <= taken ? pc_in + sx8 : pc_in;
                r_cyc <= taken ? 5'd10 : 5'd8;
                st    <= S_DONE;
              end else if (taken) begin
                r_cyc <= 5'd10; st <= S_EXT;
              end else begin
                r_pc <= pc_in + 32'd2; r_cyc <= 5'd12; st <= S_DONE;
              end
            K_BSR: begin
              r_cyc <= 5'd18;
              r_sp  <= sp_in - 32'd4;
              if (short_d) begin
                r_wd <= pc_in; r_pc <= pc_in + sx8; st <= S_PUSH;
              end else st <= S_EXT;
            end
            K_LOOP:
              if (cc_ok) begin
                r_pc <= pc_in + 32'd2; r_cyc <= 5'd12; st <= S_DONE;
              end else begin
                r_d <= {dreg_in[31:16], dec};
                if (dec == 16'hFFFF) begin
                  r_pc <= pc_in + 32'd2; r_cyc <= 5'd14; st <= S_DONE;
                end else begin
                  r_cyc <= 5'd10; st <= S_EXT;
                end
              end
            K_RET: begin
              r_cyc <= 5'd16; st <= S_POP;
            end
            K_LINK: begin
              r_cyc <= 5'd16; r_sp <= sp_in - 32'd4; st <= S_EXT;
            end
            default: begin
              r_cyc <= 5'd4; st <= S_DONE;
            end
          endcase
        end
        S_EXT: if (mem_ack) begin
          case (r_kind)
            K_BSR: begin
              r_wd <= r_pc + 32'd2; r_pc <= r_pc + sx16; st <= S_PUSH;
            end
            K_LINK: begin
              r_wd <= r_a; r_a <= r_sp + sx16;
              r_pc <= r_pc + 32'd2; st <= S_PUSH;
            end
            default: begin
              r_pc <= r_pc + sx16; st <= S_DONE;
            end
          endcase
        end
        S_PUSH: if (mem_ack) st <= S_DONE;
        S_POP: if (mem_ack) begin
          r_pc <= mem_rdata; r_sp <= r_sp + 32'd4; st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_EXT) || (st == S_PUSH) || (st == S_POP);
  assign mem_we    = (st == S_PUSH);
  assign mem_long  = (st == S_PUSH) || (st == S_POP);
  assign mem_addr  = (st == S_EXT) ? r_pc : r_sp;
  assign mem_wdata = r_wd;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign pc_out    = r_pc;
  assign sp_out    = r_sp;
  assign areg_out  = r_a;
  assign dreg_out  = r_d;
  assign cycles    = r_cyc;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  call_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && kind == K_BSR) |=> (sp_out == $past(sp_in) - 32'd4));

  // R7
  loop_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && kind == K_LOOP) |=> (dreg_out[31:16] == $past(dreg_in[31:16])));

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_long && mem_ack) |=> (done && sp_out == $past(sp_out) + 32'd4));

  // R2
  cost_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles inside {5'd4, 5'd8, 5'd10, 5'd12, 5'd14, 5'd16, 5'd18}));

  // R5
  push_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_long);

endmodule

// File: tb/tb_flow_seq.sv
module tb_flow_seq;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] kind = 0;
  logic [15:0] opcode = 0;
  logic fn = 0, fz = 0, fv = 0, fc = 0;
  logic [31:0] pc_in = 0, sp_in = 0, areg_in = 0, dreg_in = 0;
  logic mem_req, mem_we, mem_long, mem_ack = 0, busy, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] pc_out, sp_out, areg_out, dreg_out;
  logic [4:0] cycles;

  always #2 clk = ~clk;

  flow_seq dut (.clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .opcode(opcode),
    .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc), .pc_in(pc_in), .sp_in(sp_in),
    .areg_in(areg_in), .dreg_in(dreg_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
    .areg_out(areg_out), .dreg_out(dreg_out), .cycles(cycles));

  int checks = 0, errors = 0;
  int lat = 0, waitc = 0, acc_cnt = 0;
  logic [15:0] ext_word = 0;
  logic [31:0] pop_val = 0, wr_addr = 0, wr_data = 0, rd_addr = 0;

  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req) begin
      if (waitc >= lat) begin
        waitc   <= 0;
        mem_ack <= 1'b1;
        acc_cnt <= acc_cnt + 1;
        mem_rdata <= mem_long ? pop_val : {16'h0, ext_word};
        if (mem_we) begin wr_addr <= mem_addr; wr_data <= mem_wdata; end
        else rd_addr <= mem_addr;
      end else waitc <= waitc + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run(input logic [2:0] k, input logic [15:0] op, input logic [3:0] f,
                     input logic [31:0] d, input logic [15:0] e, output int n);
    @(negedge clk);
    kind = k; opcode = op; {fn, fz, fv, fc} = f; dreg_in = d; ext_word = e;
    pc_in = 32'h1000; sp_in = 32'h8000; areg_in = 32'h2000; pop_val = 32'h3456;
    acc_cnt = 0; start = 1;
    @(negedge clk);
    start = 0; n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
  endtask

  typedef struct packed {
    logic [2:0] k; logic [15:0] op; logic [3:0] f; logic [31:0] d; logic [15:0] e;
    logic [31:0] pc; logic [31:0] dx; logic [4:0] cy; logic [3:0] lt;
  } vec_t;

  // flags column is {N,Z,V,C}; kind 0 cond branch, 1 branch, 3 loop
  localparam vec_t TBL [17] = '{
    '{3'd0, 16'h0010, 4'b0000, 32'h0, 16'h0, 32'h1010, 32'h0, 5'd10, 4'd1},   // R1 R2 always
    '{3'd0, 16'h01F0, 4'b0000, 32'h0, 16'h0, 32'h1000, 32'h0, 5'd8,  4'd1},   // R1 R2 never
    '{3'd0, 16'h02FE, 4'b0000, 32'h0, 16'h0, 32'h0FFE, 32'h0, 5'd10, 4'd1},   // R1 HI taken
    '{3'd0, 16'h0204, 4'b0001, 32'h0, 16'h0, 32'h1000, 32'h0, 5'd8,  4'd1},   // R1 HI not
    '{3'd0, 16'h0300, 4'b0100, 32'h0, 16'h0100, 32'h1100, 32'h0, 5'd10, 4'd2},// R3 LS ext
    '{3'd0, 16'h0700, 4'b0000, 32'h0, 16'h0100, 32'h1002, 32'h0, 5'd12, 4'd1},// R3 skip
    '{3'd0, 16'h0C08, 4'b1010, 32'h0, 16'h0, 32'h1008, 32'h0, 5'd10, 4'd1},   // R1 GE
    '{3'd0, 16'h0D08, 4'b1010, 32'h0, 16'h0, 32'h1000, 32'h0, 5'd8,  4'd1},   // R1 LT
    '{3'd0, 16'h0E00, 4'b0000, 32'h0, 16'hFF00, 32'h0F00, 32'h0, 5'd10, 4'd2},// R3 GT back
    '{3'd0, 16'h0E08, 4'b0100, 32'h0, 16'h0, 32'h1000, 32'h0, 5'd8,  4'd1},   // R1 GT not
    '{3'd0, 16'h0F08, 4'b1000, 32'h0, 16'h0, 32'h1008, 32'h0, 5'd10, 4'd1},   // R1 LE
    '{3'd0, 16'h0B08, 4'b1000, 32'h0, 16'h0, 32'h1008, 32'h0, 5'd10, 4'd1},   // R1 MI
    '{3'd0, 16'h0908, 4'b0000, 32'h0, 16'h0, 32'h1000, 32'h0, 5'd8,  4'd1},   // R1 VS not
    '{3'd1, 16'h0180, 4'b0000, 32'h0, 16'h0, 32'h0F80, 32'h0, 5'd10, 4'd1},   // R4
    '{3'd3, 16'h0700, 4'b0100, 32'hABCD0005, 16'h0, 32'h1002, 32'hABCD0005, 5'd12, 4'd1}, // R6
    '{3'd3, 16'h0100, 4'b0000, 32'hABCD0000, 16'h0, 32'h1002, 32'hABCDFFFF, 5'd14, 4'd1}, // R7
    '{3'd3, 16'h0100, 4'b0000, 32'h12340003, 16'hFFF0, 32'h0FF0, 32'h12340002, 5'd10, 4'd2} // R8
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 done", {31'h0, done}, 0);
    chk("R13 req", {31'h0, mem_req}, 0);
    chk("R13 busy", {31'h0, busy}, 0);
    chk("R13 pc_out", pc_out, 0);
    rst_n = 1;

    foreach (TBL[i]) begin
      string tag;
      tag = (TBL[i].k == 3'd1) ? "R4" : (TBL[i].k == 3'd3) ? "R6/R7/R8" : "R1 R2 R3";
      run(TBL[i].k, TBL[i].op, TBL[i].f, TBL[i].d, TBL[i].e, n);
      chk({tag, " pc"}, pc_out, TBL[i].pc);
      chk({tag, " cycles"}, {27'h0, cycles}, {27'h0, TBL[i].cy});
      chk({tag, " dreg"}, dreg_out, TBL[i].dx);
      chk({tag, " sp kept"}, sp_out, 32'h8000);
      chk("R11 latency", n, {28'h0, TBL[i].lt});
    end

    // R5 short call
    run(3'd2, 16'h0020, 4'b0000, 32'h0, 16'h0, n);
    chk("R5 pc", pc_out, 32'h1020);
    chk("R5 sp", sp_out, 32'h7FFC);
    chk("R5 push addr", wr_addr, 32'h7FFC);
    chk("R5 push data", wr_data, 32'h1000);
    chk("R5 cycles", {27'h0, cycles}, 18);
    chk("R11 R5 latency", n, 2);

    // R5 call with extension word
    run(3'd2, 16'h0000, 4'b0000, 32'h0, 16'h0040, n);
    chk("R5 ext pc", pc_out, 32'h1040);
    chk("R5 ext push data", wr_data, 32'h1002);
    chk("R11 R5 ext latency", n, 3);

    // R9 return
    run(3'd4, 16'h0000, 4'b0000, 32'h0, 16'h0, n);
    chk("R9 pc", pc_out, 32'h3456);
    chk("R9 sp", sp_out, 32'h8004);
    chk("R9 read addr", rd_addr, 32'h8000);
    chk("R9 cycles", {27'h0, cycles}, 16);

    // R10 link, memory with 2 wait cycles
    lat = 2;
    run(3'd5, 16'h0000, 4'b0000, 32'h0, 16'hFFF8, n);
    chk("R10 pc", pc_out, 32'h1002);
    chk("R10 sp", sp_out, 32'h7FFC);
    chk("R10 areg", areg_out, 32'h7FF4);
    chk("R10 push addr", wr_addr, 32'h7FFC);
    chk("R10 push data", wr_data, 32'h2000);
    chk("R10 cycles", {27'h0, cycles}, 16);
    chk("R11 wait latency", n, 7);
    lat = 0;

    // R12 reserved kind
    run(3'd6, 16'h0010, 4'b0000, 32'h0, 16'h0, n);
    chk("R12 pc", pc_out, 32'h1000);
    chk("R12 cycles", {27'h0, cycles}, 4);
    @(negedge clk);
    chk("R11 done one cycle", {31'h0, done}, 0);

    // R12 start held while busy: return must finish unaltered
    lat = 3;
    @(negedge clk);
    kind = 3'd4; sp_in = 32'h8000; pop_val = 32'h0000ABC0; start = 1;
    @(negedge clk);
    kind = 3'd1; opcode = 16'h0040; sp_in = 32'h5000;
    n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
    start = 0;
    chk("R12 busy pc", pc_out, 32'h0000ABC0);
    chk("R12 busy sp", sp_out, 32'h8004);
    chk("R12 busy latency", n, 5);
    @(negedge clk);
    chk("R12 idle after", {31'h0, busy}, 0);
    lat = 0;

    finish_run();
  end
endmodule